// File: doc/BRIEF.md
# Two-Wire Slave Command Processor

This block is the command and register layer of a two-wire bus slave. A byte-level bus engine in front of it handles the bit timing on the wire. The engine reports START and STOP conditions and delivers each received byte. It takes back an acknowledge decision for that byte. For host reads, it fetches the byte to shift out and reports when that byte has gone.

The block first checks the device address. It then unpacks a single command byte that carries four things together: a power bit, an analog/digital selector, a three-bit function code and a three-bit register selector. Depending on the register selector, zero or two data bytes follow. These bytes load either the 16-bit memory address or one of three 16-bit configuration words. Once the last expected byte arrives, the decoded operation leaves the block as a one-cycle strobe with an operation code and the current address.

A read transaction needs no command byte. It returns a status byte, then the two address bytes. An active-low interrupt reports end-of-message and overflow events until the host reads the status byte.

Top module: `twb_cmd_front`

## Requirements
- R1: The address byte is acknowledged only when its upper seven bits equal `1 0 0 0 0 addr_pins[1] addr_pins[0]`. Bit 0 selects read (1) or write (0). On a mismatch the address byte and every later byte are not acknowledged until the next START.
- R2: The command byte has the power bit at bit 7, the analog/digital selector at bit 6, the function at bits 5:3 and the register selector at bits 2:0. Bits 6:3 map to operation codes as follows: 0000→1 (stop), 0101→2 (play), 0010→3 (record), 0111→4 (cue), 1100→5 (digital read), 1001→6 (digital write), 1010→7 (erase). Code 1000 maps to 8 (enter digital) when bit 7 is 1 and to 9 (exit digital) when bit 7 is 0. Every other code is a no-op and produces no strobe.
- R3: Register selector 001 loads the address register, and 010, 011 and 100 load configuration words 0, 1 and 2. For these selectors two data bytes follow, high byte first. Other selectors take no data bytes. The strobe and the register load happen together, one cycle after the final expected byte, and `cmd_addr` already shows any newly loaded address in that cycle.
- R4: A byte received after a write transaction has taken all its expected bytes is not acknowledged and changes nothing.
- R5: A STOP or a repeated START before all expected data bytes have arrived discards the command: no strobe, no register change, no power change.
- R6: An accepted command sets `pwr_down` to the inverse of its power bit. After reset `pwr_down` is 1, all registers are 0 and `irq_n` is 1.
- R7: When `ready_in` is low as the command byte arrives, that byte and its data bytes are still acknowledged, but the command is discarded entirely.
- R8: A read returns, in order, the status byte, address bits 15:8, and address bits 7:0 with bits 4:0 forced to zero. Any further byte reads FFh. `tx_done` advances to the next byte.
- R9: The status byte is {EOM flag, overflow flag, `ready_in`, `pwr_down`, play/record indicator, 3'b001}. The indicator becomes 1 after an accepted play and 0 after an accepted record, and is 0 after reset.
- R10: A pulse on `eom_evt` or `ovf_evt` sets its flag and drives `irq_n` low from the next cycle. Completing the status byte of a read clears both flags and releases `irq_n`. An event in the same cycle as that clear keeps its flag set.
- R11: Each received byte gets exactly one `ack_valid` pulse, in the cycle after `rx_valid`. `ack_bit` is 1 for acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_pins | input | 2 | Low two bits of the device address |
| bus_start | input | 1 | START or repeated START seen (pulse) |
| bus_stop | input | 1 | STOP seen (pulse) |
| rx_valid | input | 1 | Received byte valid (pulse) |
| rx_byte | input | 8 | Received byte |
| ack_valid | output | 1 | Acknowledge decision valid (pulse) |
| ack_bit | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| tx_byte | output | 8 | Byte to send on a host read |
| tx_done | input | 1 | Current read byte has been sent (pulse) |
| ready_in | input | 1 | Core can accept a command |
| eom_evt | input | 1 | End-of-message event (pulse) |
| ovf_evt | input | 1 | Overflow event (pulse) |
| cmd_valid | output | 1 | Decoded operation strobe |
| cmd_op | output | 4 | Operation code per R2 |
| cmd_addr | output | 16 | Address register |
| cfg0 | output | 16 | Configuration word 0 |
| cfg1 | output | 16 | Configuration word 1 |
| cfg2 | output | 16 | Configuration word 2 |
| pwr_down | output | 1 | Powered-down state |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is an event that lands in exactly the cycle the status byte completes. The flag must survive the clear. The bench drives `eom_evt` and `tx_done` on the same falling edge, then reads the status again to see the flag.

Commands that arrive while the core is busy are also awkward, because they are acknowledged yet have no effect. The bench checks this by reading the address back and watching the strobe and power output. Every command byte value is swept with data, and every address/pin combination is swept.

// File: rtl/twb_pkg.sv
package twb_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_CMD, S_HI, S_LO, S_READ
    } state_e;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_STOP   = 4'd1,
        OP_PLAY   = 4'd2,
        OP_REC    = 4'd3,
        OP_CUE    = 4'd4,
        OP_DREAD  = 4'd5,
        OP_DWRITE = 4'd6,
        OP_ERASE  = 4'd7,
        OP_DENTER = 4'd8,
        OP_DEXIT  = 4'd9
    } op_e;

    // values equal the wire encoding of the register selector
    typedef enum logic [2:0] {
        RS_NONE = 3'd0,
        RS_ADDR = 3'd1,
        RS_CFG0 = 3'd2,
        RS_CFG1 = 3'd3,
        RS_CFG2 = 3'd4
    } rsel_e;

    typedef struct packed {
        state_e      st;
        rsel_e       rsel;
        op_e         op;
        logic        pu;
        logic        drop;
        logic [7:0]  hi;
        logic [1:0]  rd_idx;
        logic [15:0] addr;
        logic [15:0] cfg0;
        logic [15:0] cfg1;
        logic [15:0] cfg2;
        logic        pd;
        logic        prb;
        logic        ack_v;
        logic        ack_b;
        logic        cmd_v;
        op_e         cmd_op;
    } fe_regs_t;

endpackage

// File: rtl/twb_cmd_decode.sv
module twb_cmd_decode
    import twb_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output logic       pwr_up,
    output op_e        op,
    output rsel_e      rsel
);
    always_comb begin
        pwr_up = cmd_byte[7];
        unique case (cmd_byte[6:3])
            4'b0000: op = OP_STOP;
            4'b0101: op = OP_PLAY;
            4'b0010: op = OP_REC;
            4'b0111: op = OP_CUE;
            4'b1100: op = OP_DREAD;
            4'b1001: op = OP_DWRITE;
            4'b1010: op = OP_ERASE;
            4'b1000: op = cmd_byte[7] ? OP_DENTER : OP_DEXIT;
            default: op = OP_NOP;
        endcase
        unique case (cmd_byte[2:0])
            3'b001:  rsel = RS_ADDR;
            3'b010:  rsel = RS_CFG0;
            3'b011:  rsel = RS_CFG1;
            3'b100:  rsel = RS_CFG2;
            default: rsel = RS_NONE;
        endcase
    end
endmodule

// File: rtl/twb_irq_flags.sv
module twb_irq_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic eom_evt,
    input  logic ovf_evt,
    input  logic clr,
    output logic eom,
    output logic ovf,
    output logic irq_n
);
    logic eom_d, eom_q, ovf_d, ovf_q, irq_n_d, irq_n_q;

    always_comb begin
        // a new event outranks the clear of the same cycle
        eom_d   = eom_evt | (eom_q & ~clr);
        ovf_d   = ovf_evt | (ovf_q & ~clr);
        irq_n_d = ~(eom_d | ovf_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eom_q   <= 1'b0;
            ovf_q   <= 1'b0;
            irq_n_q <= 1'b1;
        end else begin
            eom_q   <= eom_d;
            ovf_q   <= ovf_d;
            irq_n_q <= irq_n_d;
        end
    end

    assign eom   = eom_q;
    assign ovf   = ovf_q;
    assign irq_n = irq_n_q;
endmodule

// File: rtl/twb_cmd_front.sv
module twb_cmd_front
    import twb_pkg::*;
#(
    parameter logic [4:0] ADDR_HI  = 5'b10000,
    parameter logic [2:0] DEV_ID   = 3'b001,
    parameter int         BLK_BITS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  addr_pins,
    input  logic        bus_start,
    input  logic        bus_stop,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic        ack_valid,
    output logic        ack_bit,
    output logic [7:0]  tx_byte,
    input  logic        tx_done,
    input  logic        ready_in,
    input  logic        eom_evt,
    input  logic        ovf_evt,
    output logic        cmd_valid,
    output logic [3:0]  cmd_op,
    output logic [15:0] cmd_addr,
    output logic [15:0] cfg0,
    output logic [15:0] cfg1,
    output logic [15:0] cfg2,
    output logic        pwr_down,
    output logic        irq_n
);
    localparam int         BYTE_W   = 8;
    localparam int         REG_W    = 2 * BYTE_W;
    localparam logic [7:0] BLK_MASK = ~((8'd1 << BLK_BITS) - 8'd1);

    fe_regs_t q, d;

    logic        dec_pu;
    op_e         dec_op;
    rsel_e       dec_rsel;
    logic        commit, c_pu, c_drop, rd_clr;
    op_e         c_op;
    rsel_e       c_rsel;
    logic [REG_W-1:0] c_val;
    logic        eom_f, ovf_f;

    twb_cmd_decode u_dec (
        .cmd_byte (rx_byte),
        .pwr_up   (dec_pu),
        .op       (dec_op),
        .rsel     (dec_rsel)
    );

    twb_irq_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .eom_evt (eom_evt),
        .ovf_evt (ovf_evt),
        .clr     (rd_clr),
        .eom     (eom_f),
        .ovf     (ovf_f),
        .irq_n   (irq_n)
    );

    always_comb begin
        d        = q;
        d.ack_v  = 1'b0;
        d.cmd_v  = 1'b0;
        commit   = 1'b0;
        c_val    = '0;
        c_op     = q.op;
        c_pu     = q.pu;
        c_rsel   = q.rsel;
        c_drop   = q.drop;
        rd_clr   = 1'b0;

        if (bus_start) begin
            d.st = S_ADDR;
        end else if (bus_stop) begin
            d.st = S_IDLE;
        end else begin
            if (rx_valid) begin
                d.ack_v = 1'b1;
                d.ack_b = 1'b0;
                unique case (q.st)
                    S_ADDR: begin
                        if (rx_byte[7:1] == {ADDR_HI, addr_pins}) begin
                            d.ack_b  = 1'b1;
                            d.rd_idx = 2'd0;
                            d.st     = rx_byte[0] ? S_READ : S_CMD;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                    S_CMD: begin
                        d.ack_b = 1'b1;
                        d.pu    = dec_pu;
                        d.op    = dec_op;
                        d.rsel  = dec_rsel;
                        d.drop  = ~ready_in;
                        c_pu    = dec_pu;
                        c_op    = dec_op;
                        c_rsel  = dec_rsel;
                        c_drop  = ~ready_in;
                        if (dec_rsel == RS_NONE) begin
                            commit = 1'b1;
                            d.st   = S_IDLE;
                        end else begin
                            d.st = S_HI;
                        end
                    end
                    S_HI: begin
                        d.ack_b = 1'b1;
                        d.hi    = rx_byte;
                        d.st    = S_LO;
                    end
                    S_LO: begin
                        d.ack_b = 1'b1;
                        c_val   = {q.hi, rx_byte};
                        commit  = 1'b1;
                        d.st    = S_IDLE;
                    end
                    default: d.ack_b = 1'b0;
                endcase
            end
            if (tx_done && q.st == S_READ) begin
                rd_clr = (q.rd_idx == 2'd0);
                if (q.rd_idx != 2'd3) d.rd_idx = q.rd_idx + 2'd1;
            end
        end

        if (commit && !c_drop) begin
            d.pd = ~c_pu;
            unique case (c_rsel)
                RS_ADDR: d.addr = c_val;
                RS_CFG0: d.cfg0 = c_val;
                RS_CFG1: d.cfg1 = c_val;
                RS_CFG2: d.cfg2 = c_val;
                default: ;
            endcase
            if (c_op != OP_NOP) begin
                d.cmd_v  = 1'b1;
                d.cmd_op = c_op;
            end
            if (c_op == OP_PLAY) d.prb = 1'b1;
            if (c_op == OP_REC)  d.prb = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.pd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.rd_idx)
            2'd0:    tx_byte = {eom_f, ovf_f, ready_in, q.pd, q.prb, DEV_ID};
            2'd1:    tx_byte = q.addr[15:8];
            2'd2:    tx_byte = q.addr[7:0] & BLK_MASK;
            default: tx_byte = 8'hFF;
        endcase
    end

    assign ack_valid = q.ack_v;
    assign ack_bit   = q.ack_b;
    assign cmd_valid = q.cmd_v;
    assign cmd_op    = q.cmd_op;
    assign cmd_addr  = q.addr;
    assign cfg0      = q.cfg0;
    assign cfg1      = q.cfg1;
    assign cfg2      = q.cfg2;
    assign pwr_down  = q.pd;
endmodule

// File: rtl/twb_cmd_front_chk.sv
module twb_cmd_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_start,
    input logic        bus_stop,
    input logic        rx_valid,
    input logic        ack_valid,
    input logic        cmd_valid,
    input logic [3:0]  cmd_op,
    input logic [15:0] cfg0,
    input logic [15:0] cfg1,
    input logic [15:0] cfg2,
    input logic        pwr_down,
    input logic        eom_evt,
    input logic        ovf_evt,
    input logic        irq_n
);
    assert_ack_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !bus_start && !bus_stop) |=> ack_valid);

    assert_no_spurious_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !ack_valid);

    assert_cmd_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    assert_op_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op >= 4'd1 && cmd_op <= 4'd9));

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> ($stable(cfg0) && $stable(cfg1) && $stable(cfg2)));

    assert_pd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> $stable(pwr_down));

    assert_start_kills_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> !cmd_valid);

    assert_irq_on_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eom_evt || ovf_evt) |=> !irq_n);
endmodule

bind twb_cmd_front twb_cmd_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .rx_valid  (rx_valid),
    .ack_valid (ack_valid),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cfg0      (cfg0),
    .cfg1      (cfg1),
    .cfg2      (cfg2),
    .pwr_down  (pwr_down),
    .eom_evt   (eom_evt),
    .ovf_evt   (ovf_evt),
    .irq_n     (irq_n)
);

// File: tb/twb_cmd_front_tb.sv
module twb_cmd_front_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  addr_pins = 2'b00;
    logic        bus_start = 1'b0, bus_stop = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        ack_valid, ack_bit;
    logic [7:0]  tx_byte;
    logic        tx_done = 1'b0;
    logic        ready_in = 1'b1;
    logic        eom_evt = 1'b0, ovf_evt = 1'b0;
    logic        cmd_valid;
    logic [3:0]  cmd_op;
    logic [15:0] cmd_addr, cfg0, cfg1, cfg2;
    logic        pwr_down, irq_n;

    int n_chk = 0, n_fail = 0;
    int seen_n = 0;
    logic [3:0]  seen_op;
    logic [15:0] seen_addr;

    logic [15:0] m_addr = 16'h0, m_cfg0 = 16'h0, m_cfg1 = 16'h0, m_cfg2 = 16'h0;
    logic        m_pd = 1'b1, m_prb = 1'b0;

    always #5 clk = ~clk;

    twb_cmd_front u_dut (
        .clk(clk), .rst_n(rst_n), .addr_pins(addr_pins),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .ack_valid(ack_valid), .ack_bit(ack_bit),
        .tx_byte(tx_byte), .tx_done(tx_done), .ready_in(ready_in),
        .eom_evt(eom_evt), .ovf_evt(ovf_evt),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2),
        .pwr_down(pwr_down), .irq_n(irq_n)
    );

    always @(posedge clk) begin
        #1;
        if (cmd_valid) begin
            seen_n    = seen_n + 1;
            seen_op   = cmd_op;
            seen_addr = cmd_addr;
        end
    end

    task automatic check(input logic ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_op(input logic [7:0] c);
        case (c[6:3])
            4'b0000: return 4'd1;
            4'b0101: return 4'd2;
            4'b0010: return 4'd3;
            4'b0111: return 4'd4;
            4'b1100: return 4'd5;
            4'b1001: return 4'd6;
            4'b1010: return 4'd7;
            4'b1000: return c[7] ? 4'd8 : 4'd9;
            default: return 4'd0;
        endcase
    endfunction

    task automatic pulse_start();
        bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic pulse_stop();
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, output logic ackd);
        rx_byte = b; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        check(ack_valid === 1'b1, "R11 ack_valid after byte", ack_valid, 1);
        ackd = ack_bit;
    endtask

    task automatic rd_byte(output logic [7:0] b);
        b = tx_byte; tx_done = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic model_apply(input logic [7:0] c, input logic [15:0] v);
        if (!ready_in) return;
        m_pd = ~c[7];
        case (c[2:0])
            3'd1: m_addr = v;
            3'd2: m_cfg0 = v;
            3'd3: m_cfg1 = v;
            3'd4: m_cfg2 = v;
            default: ;
        endcase
        if (exp_op(c) == 4'd2) m_prb = 1'b1;
        if (exp_op(c) == 4'd3) m_prb = 1'b0;
    endtask

    // full write transaction, returns 1 if all bytes were acknowledged
    task automatic wr_cmd(input logic [7:0] c, input logic [15:0] v, output logic all_ack);
        logic a;
        all_ack = 1'b1;
        pulse_start();
        send(8'h80, a); all_ack &= a;
        send(c, a);     all_ack &= a;
        if (c[2:0] >= 3'd1 && c[2:0] <= 3'd4) begin
            send(v[15:8], a); all_ack &= a;
            send(v[7:0], a);  all_ack &= a;
        end
        model_apply(c, v);
        pulse_stop();
    endtask

    task automatic rd_all(input string tag);
        logic a;
        logic [7:0] b;
        pulse_start();
        send(8'h81, a);
        check(a === 1'b1, {tag, " read addr ack"}, a, 1);
        rd_byte(b);
        check(b === {1'b0, 1'b0, ready_in, m_pd, m_prb, 3'b001}, {tag, " R9 status byte"}, b,
              {1'b0, 1'b0, ready_in, m_pd, m_prb, 3'b001});
        rd_byte(b);
        check(b === m_addr[15:8], {tag, " R8 addr hi"}, b, m_addr[15:8]);
        rd_byte(b);
        check(b === {m_addr[7:5], 5'b0}, {tag, " R8 addr lo block bits zero"}, b, {m_addr[7:5], 5'b0});
        rd_byte(b);
        check(b === 8'hFF, {tag, " R8 past end"}, b, 8'hFF);
        pulse_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic a, all;
        logic [7:0] b;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 reset state
        check(pwr_down === 1'b1, "R6 reset pwr_down", pwr_down, 1);
        check(irq_n === 1'b1, "R6 reset irq_n", irq_n, 1);
        check({cfg0, cfg1, cfg2, cmd_addr} === 64'h0, "R6 reset registers", cfg0, 0);
        check(cmd_valid === 1'b0 && ack_valid === 1'b0, "R6 reset strobes", cmd_valid, 0);

        // R1 sweep of pin settings and all address byte values (write direction)
        for (int p = 0; p < 4; p++) begin
            addr_pins = p[1:0];
            for (int ad = 0; ad < 128; ad++) begin
                logic exp_a;
                exp_a = (ad[6:0] == {5'b10000, p[1:0]});
                pulse_start();
                send({ad[6:0], 1'b0}, a);
                check(a === exp_a, "R1 address match", a, exp_a);
                if (!exp_a) begin
                    send(8'h80, a);
                    check(a === 1'b0, "R1 mismatch keeps NACK", a, 0);
                end
                pulse_stop();
            end
        end
        addr_pins = 2'b00;
        check(seen_n == 0, "R1 no strobe from ignored bytes", seen_n, 0);

        // R2 R3 R4 R6 sweep over every command byte
        for (int c = 0; c < 256; c++) begin
            logic [7:0] cb;
            logic [3:0] eo;
            int n0;
            cb = c[7:0];
            v  = {cb ^ 8'h5A, ~cb};
            eo = exp_op(cb);
            n0 = seen_n;
            pulse_start();
            send(8'h80, a);
            send(cb, a);
            check(a === 1'b1, "R2 command byte ack", a, 1);
            if (cb[2:0] >= 3'd1 && cb[2:0] <= 3'd4) begin
                send(v[15:8], a);
                check(a === 1'b1, "R3 data hi ack", a, 1);
                send(v[7:0], a);
                check(a === 1'b1, "R3 data lo ack", a, 1);
            end
            model_apply(cb, v);
            check(seen_n - n0 == ((eo != 0) ? 1 : 0), "R2 strobe count", seen_n - n0, (eo != 0) ? 1 : 0);
            if (eo != 0) begin
                check(seen_op === eo, "R2 operation code", seen_op, eo);
                check(seen_addr === m_addr, "R3 cmd_addr with strobe", seen_addr, m_addr);
            end
            send(8'h3C, a);
            check(a === 1'b0, "R4 extra byte NACK", a, 0);
            check({cfg0, cfg1, cfg2} === {m_cfg0, m_cfg1, m_cfg2}, "R3 configuration words",
                  cfg0 ^ cfg1 ^ cfg2, m_cfg0 ^ m_cfg1 ^ m_cfg2);
            check(pwr_down === m_pd, "R6 power bit", pwr_down, m_pd);
            pulse_stop();
        end
        rd_all("sweep");

        // R8 R9 readback with varied addresses and play/record indicator
        wr_cmd(8'hA9, 16'hA5FF, all);
        check(all === 1'b1, "R2 play at address acks", all, 1);
        rd_all("play");
        wr_cmd(8'h91, 16'h1234, all);
        rd_all("record");
        wr_cmd(8'hE1, 16'hFFE0, all);
        rd_all("dread");

        // R7 commands ignored while busy
        ready_in = 1'b0;
        begin
            int n0;
            logic [15:0] c0;
            n0 = seen_n; c0 = cfg1;
            wr_cmd(8'h29, 16'h7777, all);
            check(all === 1'b1, "R7 busy bytes still acked", all, 1);
            wr_cmd(8'h03, 16'h4444, all);
            check(seen_n == n0, "R7 no strobe while busy", seen_n, n0);
            check(cfg1 === c0, "R7 cfg1 unchanged", cfg1, c0);
            check(pwr_down === m_pd, "R7 power unchanged", pwr_down, m_pd);
        end
        rd_all("busy");
        ready_in = 1'b1;

        // R5 STOP and repeated START before data complete
        begin
            int n0;
            n0 = seen_n;
            pulse_start(); send(8'h80, a); send(8'hA9, a); send(8'h11, a); pulse_stop();
            pulse_start(); send(8'h80, a); send(8'h04, a); send(8'h22, a);
            pulse_start(); send(8'h80, a); send(8'h00, a);
            check(a === 1'b1, "R5 restart accepted", a, 1);
            model_apply(8'h00, 16'h0);
            pulse_stop();
            check(seen_n == n0 + 1, "R5 only final command strobed", seen_n, n0 + 1);
            check(cfg2 === m_cfg2, "R5 cfg2 untouched", cfg2, m_cfg2);
            check(pwr_down === 1'b1, "R5 power from last command", pwr_down, 1);
        end
        rd_all("abort");

        // R10 interrupt set, clear on status byte, same-cycle collision
        eom_evt = 1'b1; @(negedge clk); eom_evt = 1'b0;
        check(irq_n === 1'b0, "R10 irq after eom", irq_n, 0);
        pulse_start(); send(8'h81, a);
        b = tx_byte;
        check(b[7:6] === 2'b10, "R10 status shows eom", b[7:6], 2'b10);
        rd_byte(b);
        check(irq_n === 1'b1, "R10 irq released after status", irq_n, 1);
        pulse_stop();

        ovf_evt = 1'b1; @(negedge clk); ovf_evt = 1'b0;
        check(irq_n === 1'b0, "R10 irq after ovf", irq_n, 0);
        pulse_start(); send(8'h81, a);
        b = tx_byte;
        check(b[7:6] === 2'b01, "R10 status shows ovf", b[7:6], 2'b01);
        eom_evt = 1'b1; tx_done = 1'b1;
        @(negedge clk);
        eom_evt = 1'b0; tx_done = 1'b0;
        check(irq_n === 1'b0, "R10 event wins over clear", irq_n, 0);
        pulse_stop();
        pulse_start(); send(8'h81, a);
        b = tx_byte;
        check(b[7:6] === 2'b10, "R10 surviving eom only", b[7:6], 2'b10);
        rd_byte(b);
        check(irq_n === 1'b1, "R10 final release", irq_n, 1);
        pulse_stop();

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule